// File: doc/BRIEF.md
# Radio Transceiver Configuration Loader

This block brings up a 2.4 GHz radio that is programmed through a write-only serial link. After reset it waits out the radio's power-up time, raises a chip-select strobe that puts the radio into configuration mode, waits a short setup time and then shifts a 15-byte configuration image out on a serial clock and data pair. The image is built from parameter inputs: payload length, address length, CRC size, two receive addresses, a data-rate bit, a channel number and a transmit/receive direction. Each field sits at a fixed bit position, and the bytes go out in a fixed order.

When the image has been shifted, the loader drops chip-select, pulses a done flag for one cycle and raises the radio's chip-enable if the direction is receive. Later, a single-cycle reconfigure request provides a fast path for changing channel or direction. The loader drops chip-enable, runs the same chip-select sequence, sends only the channel/direction byte, and raises chip-enable again when the new direction is receive.

All inputs are sampled when a load begins. Requests that arrive while the loader is busy are ignored.

Top module: `rfcfg_loader`

## Requirements
- R1: During reset and the power-up wait, busy_o is 1 and sck_o, mosi_o, cs_o, ce_o and done_o are 0.
- R2: After reset is released, cs_o does not rise until at least PWRUP_CYCLES clock cycles have passed.
- R3: cs_o is high for at least SETUP_CYCLES cycles before the first rising edge of sck_o. sck_o is never high while cs_o is low. cs_o stays high until the last bit of a load has been shifted.
- R4: The power-up load shifts exactly 15 bytes. Bytes 0 and 1 both hold the payload length times 8 (the payload length in bits).
- R5: Bytes 2 to 6 carry rx2_addr_i and bytes 7 to 11 carry rx1_addr_i. Each address is sent most significant byte first.
- R6: Byte 12 holds addr_len_i times 8 in bits 7:2 and a CRC code in bits 1:0. The code is 00 for crc_sel_i = 0, 01 for crc_sel_i = 1, and 11 for crc_sel_i = 2 or 3.
- R7: Byte 13 holds, from bit 7 down to bit 0: 0, 1, rate_hi_i, 011, 11. Byte 14 holds channel_i in bits 7:1 and rx_mode_i in bit 0.
- R8: Bits go out most significant bit first. sck_o idles low. Within a byte, rising edges of sck_o are CLK_DIV cycles apart and each high phase lasts CLK_DIV/2 cycles. mosi_o changes only while sck_o is low, so it is stable across every high phase.
- R9: done_o is a one-cycle pulse on the same clock edge at which cs_o falls. busy_o is 0 afterwards.
- R10: After the power-up load, ce_o equals the latched rx_mode_i.
- R11: A reconfigure request made while the loader is idle proceeds as follows. ce_o goes low before cs_o rises and stays low while cs_o is high. Exactly one byte, {channel_i, rx_mode_i}, is shifted. Afterwards ce_o equals rx_mode_i.
- R12: A reconfigure request made during the power-up wait or during a load has no effect. It starts no chip-select frame, and the byte in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| payload_len_i | input | 5 | Payload length in bytes |
| addr_len_i | input | 3 | Address length in bytes (1 to 5) |
| crc_sel_i | input | 2 | CRC size: 0 none, 1 eight-bit, 2 or 3 sixteen-bit |
| rx2_addr_i | input | 40 | Second receive address |
| rx1_addr_i | input | 40 | First receive address |
| rate_hi_i | input | 1 | Data rate: 1 high rate, 0 low rate |
| channel_i | input | 7 | Radio channel number |
| rx_mode_i | input | 1 | Direction: 1 receive, 0 transmit |
| reconf_req_i | input | 1 | One-cycle request to rewrite channel and direction |
| sck_o | output | 1 | Serial clock to the radio |
| mosi_o | output | 1 | Serial data to the radio |
| cs_o | output | 1 | Configuration-mode strobe |
| ce_o | output | 1 | Radio chip-enable |
| busy_o | output | 1 | Power-up wait or load in progress |
| done_o | output | 1 | One-cycle pulse when a load completes |

## Verification
A wrong byte index or a stale field in the image appears as a wrong byte in the captured serial stream, within that byte's eight clock periods. A wrong sequencer state appears within one cycle as one of three symptoms: an SCK edge outside the chip-select frame, chip-enable high inside the frame, or a done pulse that is not aligned with the falling chip-select edge. A divider or bit counter that is off by one shows in the first byte as a wrong SCK period, a wrong high-phase width or a wrong bit count.

// File: rtl/rfcfg_pkg.sv
package rfcfg_pkg;

    localparam int PAY_W    = 5;
    localparam int ALEN_W   = 3;
    localparam int ADDR_B   = 5;
    localparam int ADDR_W   = 8 * ADDR_B;
    localparam int CH_W     = 7;
    localparam int IMG_N    = 15;
    localparam int IDX_W    = $clog2(IMG_N + 1);
    localparam int A2_FIRST = 2;
    localparam int A1_FIRST = A2_FIRST + ADDR_B;
    localparam int B_FMT    = A1_FIRST + ADDR_B;
    localparam int B_MODE   = B_FMT + 1;
    localparam int B_CHAN   = B_MODE + 1;

    typedef struct packed {
        logic [PAY_W-1:0]  payload;
        logic [ALEN_W-1:0] addr_len;
        logic [1:0]        crc_sel;
        logic [ADDR_W-1:0] addr2;
        logic [ADDR_W-1:0] addr1;
        logic              rate_hi;
        logic [CH_W-1:0]   channel;
        logic              rx;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_CSUP,
        ST_SETUP,
        ST_SHIFT,
        ST_WAIT
    } seq_state_e;

    function automatic logic [1:0] crc_code(input logic [1:0] sel);
        case (sel)
            2'd0:    crc_code = 2'b00;
            2'd1:    crc_code = 2'b01;
            default: crc_code = 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/rfcfg_image.sv
module rfcfg_image
    import rfcfg_pkg::*;
(
    input  cfg_t             cfg_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o
);
    localparam int SLOTS = 1 << IDX_W;

    logic [7:0] img [SLOTS];

    assign img[0]      = {cfg_i.payload, 3'b000};
    assign img[1]      = {cfg_i.payload, 3'b000};
    assign img[B_FMT]  = {cfg_i.addr_len, 3'b000, crc_code(cfg_i.crc_sel)};
    assign img[B_MODE] = {1'b0, 1'b1, cfg_i.rate_hi, 3'b011, 2'b11};
    assign img[B_CHAN] = {cfg_i.channel, cfg_i.rx};

    genvar k;
    generate
        for (k = 0; k < ADDR_B; k++) begin : g_addr
            assign img[A2_FIRST + k] = cfg_i.addr2[8*(ADDR_B-1-k) +: 8];
            assign img[A1_FIRST + k] = cfg_i.addr1[8*(ADDR_B-1-k) +: 8];
        end
        for (k = IMG_N; k < SLOTS; k++) begin : g_pad
            assign img[k] = 8'h00;
        end
    endgenerate

    assign byte_o = img[idx_i];

endmodule

// File: rtl/rfcfg_shift.sv
module rfcfg_shift #(
    parameter int CLK_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [7:0] data_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = $clog2(CLK_DIV);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       bitn;
        logic [7:0]       sr;
        logic             sck;
        logic             done;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.busy) begin
            if (start_i) begin
                sh_d.busy = 1'b1;
                sh_d.sr   = data_i;
                sh_d.cnt  = '0;
                sh_d.bitn = '0;
                sh_d.sck  = 1'b0;
            end
        end else begin
            sh_d.cnt = sh_q.cnt + 1'b1;
            if (sh_q.cnt == CNT_W'(HALF - 1)) begin
                sh_d.sck = 1'b1;
            end
            if (sh_q.cnt == CNT_W'(CLK_DIV - 1)) begin
                sh_d.sck = 1'b0;
                sh_d.cnt = '0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.busy = 1'b0;
                    sh_d.done = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 1'b1;
                    sh_d.sr   = {sh_q.sr[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.busy & sh_q.sr[7];
    assign busy_o = sh_q.busy;
    assign done_o = sh_q.done;

    // R8
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_o && $past(sck_o)) |-> $stable(mosi_o));

    // R8
    byte_done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/rfcfg_seq.sv
module rfcfg_seq
    import rfcfg_pkg::*;
#(
    parameter int PWRUP_CYCLES = 24000,
    parameter int SETUP_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reconf_req_i,
    input  cfg_t             cfg_live_i,
    input  logic             sh_done_i,
    input  logic             sck_i,
    output cfg_t             cfg_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             sh_start_o,
    output logic             cs_o,
    output logic             ce_o,
    output logic             busy_o,
    output logic             done_o
);
    localparam int CNT_MAX = (PWRUP_CYCLES > SETUP_CYCLES) ? PWRUP_CYCLES : SETUP_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             full;
        cfg_t             cfg;
        logic             start;
        logic             cs;
        logic             ce;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.start = 1'b0;
        s_d.done  = 1'b0;
        case (s_q.st)
            ST_PWRUP: begin
                if (s_q.cnt == CNT_W'(PWRUP_CYCLES - 1)) begin
                    s_d.cfg  = cfg_live_i;
                    s_d.full = 1'b1;
                    s_d.cnt  = '0;
                    s_d.st   = ST_CSUP;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (reconf_req_i) begin
                    s_d.cfg.channel = cfg_live_i.channel;
                    s_d.cfg.rx      = cfg_live_i.rx;
                    s_d.full        = 1'b0;
                    s_d.ce          = 1'b0;
                    s_d.st          = ST_CSUP;
                end
            end
            ST_CSUP: begin
                s_d.cs  = 1'b1;
                s_d.cnt = '0;
                s_d.st  = ST_SETUP;
            end
            ST_SETUP: begin
                if (s_q.cnt == CNT_W'(SETUP_CYCLES - 1)) begin
                    s_d.idx = s_q.full ? '0 : IDX_W'(B_CHAN);
                    s_d.st  = ST_SHIFT;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                s_d.start = 1'b1;
                s_d.st    = ST_WAIT;
            end
            ST_WAIT: begin
                if (sh_done_i) begin
                    if (s_q.idx == IDX_W'(B_CHAN)) begin
                        s_d.cs   = 1'b0;
                        s_d.done = 1'b1;
                        s_d.ce   = s_q.cfg.rx;
                        s_d.st   = ST_IDLE;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                        s_d.st  = ST_SHIFT;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= ST_PWRUP;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_o      = s_q.cfg;
    assign idx_o      = s_q.idx;
    assign sh_start_o = s_q.start;
    assign cs_o       = s_q.cs;
    assign ce_o       = s_q.ce;
    assign busy_o     = (s_q.st != ST_IDLE);
    assign done_o     = s_q.done;

    // R3
    sck_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck_i |-> cs_o);

    // R11
    ce_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_o |-> !ce_o);

    // R9
    done_at_cs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $fell(cs_o));

    // R2
    quiet_pwrup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_PWRUP) |-> (!cs_o && !ce_o && busy_o));

    // R12
    req_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reconf_req_i && s_q.st == ST_WAIT) |=> (s_q.st == ST_WAIT || s_q.st == ST_SHIFT || s_q.st == ST_IDLE));

endmodule

// File: rtl/rfcfg_loader.sv
module rfcfg_loader
    import rfcfg_pkg::*;
#(
    parameter int CLK_DIV      = 8,
    parameter int PWRUP_CYCLES = 24000,
    parameter int SETUP_CYCLES = 40
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  payload_len_i,
    input  logic [2:0]  addr_len_i,
    input  logic [1:0]  crc_sel_i,
    input  logic [39:0] rx2_addr_i,
    input  logic [39:0] rx1_addr_i,
    input  logic        rate_hi_i,
    input  logic [6:0]  channel_i,
    input  logic        rx_mode_i,
    input  logic        reconf_req_i,
    output logic        sck_o,
    output logic        mosi_o,
    output logic        cs_o,
    output logic        ce_o,
    output logic        busy_o,
    output logic        done_o
);
    cfg_t             cfg_live, cfg_held;
    logic [IDX_W-1:0] idx;
    logic [7:0]       cur_byte;
    logic             sh_start, sh_done, sh_busy, sck;

    always_comb begin
        cfg_live          = '0;
        cfg_live.payload  = payload_len_i;
        cfg_live.addr_len = addr_len_i;
        cfg_live.crc_sel  = crc_sel_i;
        cfg_live.addr2    = rx2_addr_i;
        cfg_live.addr1    = rx1_addr_i;
        cfg_live.rate_hi  = rate_hi_i;
        cfg_live.channel  = channel_i;
        cfg_live.rx       = rx_mode_i;
    end

    rfcfg_seq #(
        .PWRUP_CYCLES (PWRUP_CYCLES),
        .SETUP_CYCLES (SETUP_CYCLES)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .reconf_req_i (reconf_req_i),
        .cfg_live_i   (cfg_live),
        .sh_done_i    (sh_done),
        .sck_i        (sck),
        .cfg_o        (cfg_held),
        .idx_o        (idx),
        .sh_start_o   (sh_start),
        .cs_o         (cs_o),
        .ce_o         (ce_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    rfcfg_image image_i (
        .cfg_i  (cfg_held),
        .idx_i  (idx),
        .byte_o (cur_byte)
    );

    rfcfg_shift #(
        .CLK_DIV (CLK_DIV)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sh_start),
        .data_i  (cur_byte),
        .sck_o   (sck),
        .mosi_o  (mosi_o),
        .busy_o  (sh_busy),
        .done_o  (sh_done)
    );

    assign sck_o = sck;

    // R8
    sck_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> sh_busy);

endmodule

// File: tb/rfcfg_loader_tb_top.sv
`timescale 1ns/1ps
module rfcfg_loader_tb_top;
    localparam int DIV   = 8;
    localparam int PWRUP = 40;
    localparam int SETUP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  payload_len_i = '0;
    logic [2:0]  addr_len_i = '0;
    logic [1:0]  crc_sel_i = '0;
    logic [39:0] rx2_addr_i = '0, rx1_addr_i = '0;
    logic        rate_hi_i = 1'b0;
    logic [6:0]  channel_i = '0;
    logic        rx_mode_i = 1'b0;
    logic        reconf_req_i = 1'b0;
    logic        sck_o, mosi_o, cs_o, ce_o, busy_o, done_o;

    always #4 clk = ~clk;

    rfcfg_loader #(.CLK_DIV(DIV), .PWRUP_CYCLES(PWRUP), .SETUP_CYCLES(SETUP)) dut_i (
        .clk(clk), .rst_n(rst_n), .payload_len_i(payload_len_i), .addr_len_i(addr_len_i),
        .crc_sel_i(crc_sel_i), .rx2_addr_i(rx2_addr_i), .rx1_addr_i(rx1_addr_i),
        .rate_hi_i(rate_hi_i), .channel_i(channel_i), .rx_mode_i(rx_mode_i),
        .reconf_req_i(reconf_req_i), .sck_o(sck_o), .mosi_o(mosi_o), .cs_o(cs_o),
        .ce_o(ce_o), .busy_o(busy_o), .done_o(done_o));

    // reconfigure vectors: {channel, rx, expected byte}
    localparam logic [15:0] RC_VEC [5] = '{
        {7'd5,   1'b1, 8'h0B},
        {7'd0,   1'b0, 8'h00},
        {7'd127, 1'b1, 8'hFF},
        {7'd64,  1'b0, 8'h80},
        {7'd42,  1'b1, 8'h55}
    };

    int checks = 0, fails = 0;
    int cyc = 0, rel_cyc = 0;
    int cs_rises = 0, cs_rise_cyc = 0, first_rise_cyc = 0, last_rise = 0, nbits = 0;
    int per_bad = 0, hi_bad = 0, hi_run = 0, mosi_bad = 0, sck_nocs = 0;
    int done_bad = 0, ce_bad = 0;
    logic prev_sck = 0, prev_cs = 0, prev_done = 0, prev_mosi = 0;
    logic [7:0] cap [16];

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (cs_o && !prev_cs) begin
            cs_rises    = cs_rises + 1;
            cs_rise_cyc = cyc;
            nbits       = 0;
        end
        if (sck_o && !prev_sck) begin
            if (nbits == 0) first_rise_cyc = cyc;
            else if ((nbits % 8) != 0 && (cyc - last_rise) != DIV) per_bad = per_bad + 1;
            last_rise = cyc;
            if (nbits < 128) cap[nbits/8] = {cap[nbits/8][6:0], mosi_o};
            nbits = nbits + 1;
        end
        if (sck_o) hi_run = prev_sck ? hi_run + 1 : 1;
        if (!sck_o && prev_sck && hi_run != DIV/2) hi_bad = hi_bad + 1;
        if (sck_o && prev_sck && mosi_o != prev_mosi) mosi_bad = mosi_bad + 1;
        if (sck_o && !cs_o) sck_nocs = sck_nocs + 1;
        if (cs_o && ce_o) ce_bad = ce_bad + 1;
        if (done_o && (cs_o || !prev_cs || prev_done)) done_bad = done_bad + 1;
        prev_sck = sck_o; prev_cs = cs_o; prev_done = done_o; prev_mosi = mosi_o;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done_o !== 1'b1 && guard < 20000) begin
            tick(1);
            guard++;
        end
        tick(3);
    endtask

    task automatic full_case(input logic [4:0] pay, input logic [2:0] alen, input logic [1:0] crc,
                             input logic [39:0] a2, input logic [39:0] a1, input logic rate,
                             input logic [6:0] ch, input logic rx, input logic [119:0] exp,
                             input logic ce_exp);
        int rises0;
        tick(1);
        rst_n = 1'b0;
        payload_len_i = pay; addr_len_i = alen; crc_sel_i = crc;
        rx2_addr_i = a2; rx1_addr_i = a1; rate_hi_i = rate;
        channel_i = ch; rx_mode_i = rx;
        tick(4);
        // R1: reset state
        chk("R1 reset outputs {sck,mosi,cs,ce,done}", {sck_o, mosi_o, cs_o, ce_o, done_o}, 5'b0);
        chk("R1 busy in reset", busy_o, 1'b1);
        rises0 = cs_rises;
        rst_n = 1'b1;
        rel_cyc = cyc;
        tick(PWRUP / 2);
        chk("R1 quiet during power-up", {cs_o, ce_o, sck_o, busy_o}, 4'b0001);
        // R12: request during power-up is ignored
        reconf_req_i = 1'b1; tick(1); reconf_req_i = 1'b0;
        wait_done();
        tick(40);
        chk("R12 one frame only", cs_rises - rises0, 1);
        chk("R2 power-up gap", (cs_rise_cyc - rel_cyc) >= PWRUP, 1'b1);
        chk("R3 setup gap", (first_rise_cyc - cs_rise_cyc) >= SETUP, 1'b1);
        chk("R4 bit count", nbits, 120);
        for (int i = 0; i < 15; i++) begin
            string tag;
            tag = (i < 2) ? "R4 width byte" : (i < 12) ? "R5 address byte" :
                  (i == 12) ? "R6 format byte" : "R7 control byte";
            chk($sformatf("%s %0d", tag, i), cap[i], exp[8*(14-i) +: 8]);
        end
        chk("R9 busy after load", busy_o, 1'b0);
        chk("R10 ce after load", ce_o, ce_exp);
    endtask

    initial begin
        int rises0;
        // case A: 12-byte payload, 3-byte address, 16-bit CRC, low rate, channel 2 transmit
        full_case(5'd12, 3'd3, 2'd2, 40'h0, 40'h00_00_4C_55_AF, 1'b0, 7'd2, 1'b0,
                  120'h60_60_00_00_00_00_00_00_00_4C_55_AF_63_4F_04, 1'b0);

        // R11: reconfigure vectors
        for (int v = 0; v < 5; v++) begin
            rises0 = cs_rises;
            channel_i = RC_VEC[v][15:9];
            rx_mode_i = RC_VEC[v][8];
            reconf_req_i = 1'b1; tick(1); reconf_req_i = 1'b0;
            wait_done();
            chk($sformatf("R11 vec %0d frames", v), cs_rises - rises0, 1);
            chk($sformatf("R11 vec %0d bits", v), nbits, 8);
            chk($sformatf("R11 vec %0d byte", v), cap[0], RC_VEC[v][7:0]);
            chk($sformatf("R11 vec %0d ce", v), ce_o, RC_VEC[v][8]);
            tick(5);
        end

        // R12: request while a reconfigure is in flight is ignored
        rises0 = cs_rises;
        channel_i = 7'd5; rx_mode_i = 1'b1;
        reconf_req_i = 1'b1; tick(1); reconf_req_i = 1'b0;
        tick(SETUP + 12);
        channel_i = 7'd9; rx_mode_i = 1'b0;
        reconf_req_i = 1'b1; tick(1); reconf_req_i = 1'b0;
        wait_done();
        tick(200);
        chk("R12 frames while busy", cs_rises - rises0, 1);
        chk("R12 byte unchanged", cap[0], 8'h0B);
        chk("R12 ce unchanged", ce_o, 1'b1);

        // case B: 31-byte payload, 5-byte address, 8-bit CRC, high rate, receive
        full_case(5'd31, 3'd5, 2'd1, 40'h11_22_33_44_55, 40'hA5_5A_C3_3C_0F, 1'b1, 7'd100, 1'b1,
                  120'hF8_F8_11_22_33_44_55_A5_5A_C3_3C_0F_A1_6F_C9, 1'b1);
        // case C: crc select 3 maps to 11
        full_case(5'd1, 3'd1, 2'd3, 40'hFF_FF_FF_FF_FF, 40'h01_02_04_08_10, 1'b0, 7'd0, 1'b1,
                  120'h08_08_FF_FF_FF_FF_FF_01_02_04_08_10_23_4F_01, 1'b1);
        // case D: no CRC
        full_case(5'd1, 3'd1, 2'd0, 40'hFF_FF_FF_FF_FF, 40'h01_02_04_08_10, 1'b0, 7'd127, 1'b0,
                  120'h08_08_FF_FF_FF_FF_FF_01_02_04_08_10_20_4F_FE, 1'b0);

        chk("R8 sck period", per_bad, 0);
        chk("R8 sck high phase", hi_bad, 0);
        chk("R8 mosi stable while high", mosi_bad, 0);
        chk("R3 sck outside frame", sck_nocs, 0);
        chk("R9 done alignment", done_bad, 0);
        chk("R11 ce inside frame", ce_bad, 0);
        summary();
        $finish;
    end
endmodule